// File: doc/BRIEF.md
# Bus Target Address-Phase Claim Decoder

This block sits at the front of a parallel-bus target. It looks at every address phase and decides whether this target should respond to it. Software programs a small set of base registers with the memory and I/O windows the target owns. Each window has a fixed power-of-two size, so the low address bits inside the window are not compared.

Each address phase is checked against those windows and against the command code. The command code must be a memory read, memory write, I/O read or I/O write. Memory windows hold a 64-bit base. An initiator reaches a window above 4 GB with a two-cycle dual address cycle. In the first cycle the bus carries the low address word under the dual-address command. In the second cycle it carries the high address word and the real command.

One cycle after the final address cycle, the block reports four results:
- a claim pulse,
- the transfer direction (bit 0 of the real command),
- the index of the window that was hit,
- the full 64-bit address.

Data-phase handshaking lies outside this block.

Top module: `tgtAddrDecode`

## Requirements
- R1: When an address phase hits a window with a supported command, `claim` is high exactly one cycle after the final address cycle, and `barHit` gives that window's index.
- R2: `isWrite` equals bit 0 of the real command code. Memory read is 4'b0110 and gives 0. Memory write is 4'b0111 and gives 1. I/O read is 4'b0010 and I/O write is 4'b0011.
- R3: The command 4'b1101 starts a dual address cycle. The bus word in that cycle is the low address half, and it never produces a claim. The next cycle supplies the high half on `ad` and the real command on `cbe`. The result follows one cycle later, and `addrLat` holds {high, low}.
- R4: A command other than the four supported codes is never claimed, even when the address hits a window. This includes 4'b1101 given as the real command of a dual address cycle.
- R5: An address outside every window gives no claim, and `claim` stays low.
- R6: Memory commands match only memory windows. I/O commands match only I/O windows. With the default parameters, windows 0 and 1 are memory windows of 4 KB and window 2 is an I/O window of 256 bytes.
- R7: Base bits below the window size are stored as zero, so written values there have no effect. Address bits below the window size are ignored in the compare. Writes to the upper half of an I/O window have no effect.
- R8: A single-cycle address phase has an upper address half of zero, and `addrLat[63:32]` reads zero after it. A memory window whose upper base is non-zero is reached only through a dual address cycle.
- R9: When more than one window matches, the lowest index wins.
- R10: After reset, `claim`, `isWrite`, `barHit` and `addrLat` are zero. `claim` is a one-cycle pulse for each claimed transaction.
- R11: An I/O command given in the second cycle of a dual address cycle is not claimed.
- R12: A `frameStart` in the second cycle of a dual address cycle is not a new address phase. That cycle is still decoded as the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Base-register write strobe |
| cfgWrIdx | input | IDX_W | Window index written |
| cfgWrHi | input | 1 | 1 selects the upper 32 base bits |
| cfgWrData | input | 32 | Base value written |
| frameStart | input | 1 | High in the first cycle of an address phase |
| ad | input | 32 | Multiplexed address bus |
| cbe | input | 4 | Command code during address cycles |
| claim | output | 1 | One-cycle claim pulse |
| isWrite | output | 1 | Direction of the decoded transaction |
| barHit | output | IDX_W | Index of the window hit |
| addrLat | output | 64 | Latched full address of the last decoded phase |

## Verification
All four results are registered once. They are due one clock edge after the final address cycle. For a single-cycle phase that is the edge after the `frameStart` cycle. For a dual address cycle it is the edge after the high-half cycle.

The bench drives on the falling edge. It samples on the next falling edge, which is half a period after the deciding rising edge. For dual address cycles it also samples once between the two cycles, to confirm that no claim appears early. It samples once more after each result, to confirm the claim pulse has dropped.

// File: rtl/tgtDecPkg.sv
package tgtDecPkg;
  localparam int AD_W = 32;

  typedef enum logic [3:0] {
    CMD_IORD = 4'b0010,
    CMD_IOWR = 4'b0011,
    CMD_MRD  = 4'b0110,
    CMD_MWR  = 4'b0111,
    CMD_DAC  = 4'b1101
  } busCmd_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DACHI = 1'b1
  } decState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchLo;  // capture low address half (first dual cycle)
    logic decode;   // final address cycle: compare and register results
    logic useDac;   // current cycle is the high half of a dual cycle
  } ctlStrobe_t;
endpackage

// File: rtl/tgtDecCtl.sv
module tgtDecCtl
  import tgtDecPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic [3:0] cbe,
  output ctlStrobe_t strobes
);
  decState_e state, stateNext;
  logic      startDac;

  assign startDac = (state == ST_IDLE) && frameStart && (cbe == CMD_DAC);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (startDac) stateNext = ST_DACHI;
      ST_DACHI: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.latchLo = startDac;
    strobes.useDac  = (state == ST_DACHI);
    strobes.decode  = (state == ST_DACHI) ||
                      ((state == ST_IDLE) && frameStart && (cbe != CMD_DAC));
  end
endmodule

// File: rtl/tgtDecBars.sv
module tgtDecBars
  import tgtDecPkg::*;
#(
  parameter int                NUM_BARS      = 3,
  parameter int                MEM_SIZE_LOG2 = 12,
  parameter int                IO_SIZE_LOG2  = 8,
  parameter logic [NUM_BARS-1:0] IO_BAR_MAP  = 3'b100,
  parameter int                IDX_W         = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [IDX_W-1:0]    cfgWrIdx,
  input  logic                cfgWrHi,
  input  logic [AD_W-1:0]     cfgWrData,
  input  logic [2*AD_W-1:0]   cmpAddr,
  input  logic                wantMem,
  input  logic                wantIo,
  output logic [NUM_BARS-1:0] hitVec
);
  localparam logic [AD_W-1:0] MEM_KEEP = ~((AD_W'(1) << MEM_SIZE_LOG2) - AD_W'(1));
  localparam logic [AD_W-1:0] IO_KEEP  = ~((AD_W'(1) << IO_SIZE_LOG2) - AD_W'(1));

  logic [AD_W-1:0] cmpLo, cmpHi;
  assign cmpLo = cmpAddr[AD_W-1:0];
  assign cmpHi = cmpAddr[2*AD_W-1:AD_W];

  for (genvar g = 0; g < NUM_BARS; g++) begin : gBar
    logic selW;
    assign selW = cfgWrEn && (cfgWrIdx == IDX_W'(g));

    if (IO_BAR_MAP[g]) begin : gIo
      logic [AD_W-1:0] baseLo;
      always_ff @(posedge clk) begin
        if (!rstN)                  baseLo <= '0;
        else if (selW && !cfgWrHi)  baseLo <= cfgWrData & IO_KEEP;
      end
      assign hitVec[g] = wantIo && (cmpHi == '0) && ((cmpLo & IO_KEEP) == baseLo);
    end else begin : gMem
      logic [AD_W-1:0] baseLo, baseHi;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          baseLo <= '0;
          baseHi <= '0;
        end else if (selW) begin
          if (cfgWrHi) baseHi <= cfgWrData;
          else         baseLo <= cfgWrData & MEM_KEEP;
        end
      end
      assign hitVec[g] = wantMem && (cmpHi == baseHi) && ((cmpLo & MEM_KEEP) == baseLo);
    end
  end
endmodule

// File: rtl/tgtDecPath.sv
module tgtDecPath
  import tgtDecPkg::*;
#(
  parameter int NUM_BARS = 3,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobes,
  input  logic [AD_W-1:0]     ad,
  input  logic [3:0]          cbe,
  input  logic [NUM_BARS-1:0] hitVec,
  output logic [2*AD_W-1:0]   cmpAddr,
  output logic                wantMem,
  output logic                wantIo,
  output logic                claim,
  output logic                isWrite,
  output logic [IDX_W-1:0]    barHit,
  output logic [2*AD_W-1:0]   addrLat
);
  logic [AD_W-1:0]  loLatch;
  logic [IDX_W-1:0] selIdx;
  logic             anyHit;
  logic             cmdMem, cmdIo;

  assign cmpAddr = strobes.useDac ? {ad, loLatch} : {{AD_W{1'b0}}, ad};
  assign cmdMem  = (cbe == CMD_MRD)  || (cbe == CMD_MWR);
  assign cmdIo   = (cbe == CMD_IORD) || (cbe == CMD_IOWR);
  assign wantMem = strobes.decode && cmdMem;
  assign wantIo  = strobes.decode && cmdIo && !strobes.useDac;
  assign anyHit  = |hitVec;

  // lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_BARS - 1; i >= 0; i--) begin
      if (hitVec[i]) selIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loLatch <= '0;
      claim   <= 1'b0;
      isWrite <= 1'b0;
      barHit  <= '0;
      addrLat <= '0;
    end else begin
      if (strobes.latchLo) loLatch <= ad;
      claim <= strobes.decode && anyHit;
      if (strobes.decode) begin
        isWrite <= cbe[0];
        barHit  <= anyHit ? selIdx : '0;
        addrLat <= cmpAddr;
      end
    end
  end
endmodule

// File: rtl/tgtAddrDecode.sv
module tgtAddrDecode
  import tgtDecPkg::*;
#(
  parameter int                  NUM_BARS      = 3,
  parameter int                  MEM_SIZE_LOG2 = 12,
  parameter int                  IO_SIZE_LOG2  = 8,
  parameter logic [NUM_BARS-1:0] IO_BAR_MAP    = 3'b100,
  localparam int                 IDX_W         = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [IDX_W-1:0]    cfgWrIdx,
  input  logic                cfgWrHi,
  input  logic [31:0]         cfgWrData,
  input  logic                frameStart,
  input  logic [31:0]         ad,
  input  logic [3:0]          cbe,
  output logic                claim,
  output logic                isWrite,
  output logic [IDX_W-1:0]    barHit,
  output logic [63:0]         addrLat
);
  ctlStrobe_t          strobes;
  logic [63:0]         cmpAddr;
  logic                wantMem, wantIo;
  logic [NUM_BARS-1:0] hitVec;

  tgtDecCtl uCtl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .cbe(cbe), .strobes(strobes)
  );

  tgtDecBars #(
    .NUM_BARS(NUM_BARS), .MEM_SIZE_LOG2(MEM_SIZE_LOG2), .IO_SIZE_LOG2(IO_SIZE_LOG2),
    .IO_BAR_MAP(IO_BAR_MAP), .IDX_W(IDX_W)
  ) uBars (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx), .cfgWrHi(cfgWrHi),
    .cfgWrData(cfgWrData), .cmpAddr(cmpAddr), .wantMem(wantMem), .wantIo(wantIo),
    .hitVec(hitVec)
  );

  tgtDecPath #(.NUM_BARS(NUM_BARS), .IDX_W(IDX_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ad(ad), .cbe(cbe), .hitVec(hitVec),
    .cmpAddr(cmpAddr), .wantMem(wantMem), .wantIo(wantIo), .claim(claim),
    .isWrite(isWrite), .barHit(barHit), .addrLat(addrLat)
  );
endmodule

// File: rtl/tgtDecChk.sv
module tgtDecChk
  import tgtDecPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        frameStart,
  input logic [31:0] ad,
  input logic [3:0]  cbe,
  input ctlStrobe_t  strobes,
  input logic        claim,
  input logic        isWrite,
  input logic [63:0] addrLat
);
  logic cmdOk, cmdIo;
  assign cmdOk = (cbe == CMD_MRD) || (cbe == CMD_MWR) || (cbe == CMD_IORD) || (cbe == CMD_IOWR);
  assign cmdIo = (cbe == CMD_IORD) || (cbe == CMD_IOWR);

  // R1: a claim only follows a final address cycle
  a_r1_claim_after_phase: assert property (@(posedge clk) disable iff (!rstN)
    claim |-> $past(strobes.decode));

  // R2: direction is bit 0 of the real command
  a_r2_direction: assert property (@(posedge clk) disable iff (!rstN)
    claim |-> (isWrite == $past(cbe[0])));

  // R3: first dual-address cycle never claims
  a_r3_dac_first_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && (cbe == CMD_DAC) && !strobes.useDac) |=> !claim);

  // R3: full address after a dual cycle
  a_r3_dac_address: assert property (@(posedge clk) disable iff (!rstN)
    (claim && $past(strobes.useDac)) |-> (addrLat == {$past(ad), $past(ad, 2)}));

  // R4: unsupported command never claimed
  a_r4_unsupported: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decode && !cmdOk) |=> !claim);

  // R8: single-cycle phase leaves the upper address zero
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decode && !strobes.useDac) |=> (addrLat[63:32] == 32'h0));

  // R11: no I/O claim through a dual cycle
  a_r11_io_dac: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.useDac && cmdIo) |=> !claim);

  // R12: high-half cycle lasts exactly one cycle
  a_r12_dac_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    strobes.useDac |=> !strobes.useDac);
endmodule

bind tgtAddrDecode tgtDecChk uChk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .ad(ad), .cbe(cbe),
  .strobes(strobes), .claim(claim), .isWrite(isWrite), .addrLat(addrLat)
);

// File: tb/tb_tgtAddrDecode.sv
module tb_tgtAddrDecode;
  import tgtDecPkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgWrIdx = '0;
  logic        cfgWrHi = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        frameStart = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic        claim, isWrite;
  logic [1:0]  barHit;
  logic [63:0] addrLat;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tgtAddrDecode dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx), .cfgWrHi(cfgWrHi),
    .cfgWrData(cfgWrData), .frameStart(frameStart), .ad(ad), .cbe(cbe),
    .claim(claim), .isWrite(isWrite), .barHit(barHit), .addrLat(addrLat)
  );

  typedef struct packed {
    logic        dac;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [3:0]  cmd;
    logic        eClaim;
    logic        eWr;
    logic [1:0]  eIdx;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h8000_0010, 32'h0, 4'b0110, 1'b1, 1'b0, 2'd0, 4'd1},  // R1 R2 read hit
    '{1'b0, 32'h8000_0FFC, 32'h0, 4'b0111, 1'b1, 1'b1, 2'd0, 4'd7},  // R7 R2 top of window
    '{1'b0, 32'h8000_1000, 32'h0, 4'b0110, 1'b0, 1'b0, 2'd0, 4'd5},  // R5 just past window
    '{1'b0, 32'h8000_0010, 32'h0, 4'b0010, 1'b0, 1'b0, 2'd0, 4'd6},  // R6 I/O cmd at mem addr
    '{1'b0, 32'h0000_10F0, 32'h0, 4'b0011, 1'b1, 1'b1, 2'd2, 4'd6},  // R6 R7 I/O write hit
    '{1'b0, 32'h0000_1010, 32'h0, 4'b0110, 1'b0, 1'b0, 2'd0, 4'd6},  // R6 mem cmd at I/O addr
    '{1'b0, 32'h8000_0010, 32'h0, 4'b0000, 1'b0, 1'b0, 2'd0, 4'd4},  // R4 unsupported
    '{1'b0, 32'h8000_0010, 32'h0, 4'b1100, 1'b0, 1'b0, 2'd0, 4'd4},  // R4 unsupported
    '{1'b0, 32'h4000_0020, 32'h0, 4'b0110, 1'b0, 1'b0, 2'd0, 4'd8},  // R8 high window, single
    '{1'b1, 32'h4000_0020, 32'h2, 4'b0111, 1'b1, 1'b1, 2'd1, 4'd3},  // R3 dual hit
    '{1'b1, 32'h4000_0020, 32'h3, 4'b0110, 1'b0, 1'b0, 2'd0, 4'd5},  // R5 dual miss upper
    '{1'b1, 32'h0000_1010, 32'h0, 4'b0010, 1'b0, 1'b0, 2'd0, 4'd11}, // R11 I/O via dual
    '{1'b1, 32'h8000_0010, 32'h0, 4'b0110, 1'b1, 1'b0, 2'd0, 4'd3},  // R3 dual, zero upper
    '{1'b1, 32'h8000_0010, 32'h0, 4'b1101, 1'b0, 1'b0, 2'd0, 4'd4}   // R4 dual as real cmd
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] idx, input logic hi, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrIdx = idx; cfgWrHi = hi; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // leaves the bench at the negedge where the result is visible
  task automatic runTxn(input logic dac, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [3:0] cmd, input logic fsSecond);
    @(negedge clk);
    if (dac) begin
      frameStart = 1'b1; ad = lo; cbe = CMD_DAC;
      @(negedge clk);
      check("R3 no claim after first dual cycle", {63'h0, claim}, 64'h0);
      frameStart = fsSecond; ad = hi; cbe = cmd;
    end else begin
      frameStart = 1'b1; ad = lo; cbe = cmd;
    end
    @(negedge clk);
    frameStart = 1'b0; ad = '0; cbe = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 claim after reset", {63'h0, claim}, 64'h0);
    check("R10 isWrite after reset", {63'h0, isWrite}, 64'h0);
    check("R10 barHit after reset", {62'h0, barHit}, 64'h0);
    check("R10 addrLat after reset", addrLat, 64'h0);

    cfgWrite(2'd0, 1'b0, 32'h8000_0ABC);  // R7 low bits dropped
    cfgWrite(2'd0, 1'b1, 32'h0);
    cfgWrite(2'd1, 1'b0, 32'h4000_0020);
    cfgWrite(2'd1, 1'b1, 32'h2);
    cfgWrite(2'd2, 1'b0, 32'h0000_1055);
    cfgWrite(2'd2, 1'b1, 32'hFFFF_FFFF);  // R7 ignored for I/O window

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      runTxn(VECS[i].dac, VECS[i].lo, VECS[i].hi, VECS[i].cmd, 1'b0);
      check({tag, " claim"}, {63'h0, claim}, {63'h0, VECS[i].eClaim});
      check({tag, " addrLat"}, addrLat,
            VECS[i].dac ? {VECS[i].hi, VECS[i].lo} : {32'h0, VECS[i].lo});
      if (VECS[i].eClaim) begin
        check({tag, " isWrite"}, {63'h0, isWrite}, {63'h0, VECS[i].eWr});
        check({tag, " barHit"}, {62'h0, barHit}, {62'h0, VECS[i].eIdx});
      end
      @(negedge clk);
      check("R10 claim is one pulse", {63'h0, claim}, 64'h0);
    end

    // R12: frameStart during the high-half cycle
    runTxn(1'b1, 32'h4000_0020, 32'h2, 4'b0110, 1'b1);
    check("R12 claim", {63'h0, claim}, 64'h1);
    check("R12 barHit", {62'h0, barHit}, 64'h1);
    check("R12 isWrite", {63'h0, isWrite}, 64'h0);
    check("R12 addrLat", addrLat, 64'h0000_0002_4000_0020);
    @(negedge clk);
    check("R12 no extra claim", {63'h0, claim}, 64'h0);

    // R9: overlapping windows, lowest index wins
    cfgWrite(2'd1, 1'b1, 32'h0);
    cfgWrite(2'd1, 1'b0, 32'h8000_0000);
    runTxn(1'b0, 32'h8000_0040, 32'h0, 4'b0111, 1'b0);
    check("R9 claim", {63'h0, claim}, 64'h1);
    check("R9 barHit lowest", {62'h0, barHit}, 64'h0);

    // R1 back-to-back single phases
    @(negedge clk);
    frameStart = 1'b1; ad = 32'h8000_0100; cbe = 4'b0110;
    @(negedge clk);
    check("R1 first of pair", {63'h0, claim}, 64'h1);
    ad = 32'h0000_0100;
    @(negedge clk);
    frameStart = 1'b0; ad = '0; cbe = '0;
    check("R5 second of pair misses", {63'h0, claim}, 64'h0);
    check("R1 second address latched", addrLat, 64'h0000_0000_0000_0100);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule